// File: doc/BRIEF.md
# Logical Device Address Window Decoder

This block turns a host I/O address into chip-select lines for six logical devices of a multi-function peripheral chip: a floppy controller, two serial ports, a parallel port, a four-register auxiliary two-wire bus controller and a single auxiliary I/O register. Each device has a global enable bit, a local activate flag and a 16-bit base address. The base address is built from a high configuration byte and a low configuration byte. All of these come in as static configuration inputs that may change at any time.

A device is selected when it is enabled at both levels, its base lies inside the range allowed for its kind, and the address falls inside its window. The window has a fixed width and starts at the base. The block drives one select per device. It also drives a register offset, taken from the device that wins under a fixed priority, and a flag that is high when any device matches. The whole decode is combinational: the outputs follow the address and configuration in the same cycle, with no register anywhere on the path.

Top module: `sio_addr_window`

## Requirements
- R1: A device's select can be high only when both its global enable bit and its local activate bit are 1. If either bit is 0, the select is 0 whatever the address.
- R2: The base of device i is `{cfg_base_hi[8i+7:8i], cfg_base_lo[8i+7:8i]}`, with the high byte in bits 15:8.
- R3: Device indices are: 0 floppy, 1 serial A, 2 serial B, 3 parallel, 4 auxiliary bus, 5 auxiliary I/O register. The legal base range is 0x0100 to 0x0FF8 for devices 0, 1 and 2. It is 0x0100 to 0x0FFC for devices 3 and 4, and 0x0100 to 0x0FFF for device 5. A base outside its range holds that device's select at 0.
- R4: The window width is 8 bytes for devices 0, 1 and 2, 4 bytes for devices 3 and 4, and 1 byte for device 5. An enabled device with a legal base is selected exactly when base <= io_addr < base + width.
- R5: `reg_ofs` equals `io_addr & (width - 1)` of the winning device, so it carries three low bits, two low bits or zero bits. It is 0 when no device is selected.
- R6: When several selects are high at once, all of them are driven. The offset comes from the lowest-numbered selected device, and `any_hit` is the OR of all selects.
- R7: All outputs depend only on the present inputs and change in the same cycle as the inputs, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 16 | Host I/O address being decoded |
| cfg_glb_en | input | 6 | Global enable bit per device |
| cfg_act | input | 6 | Local activate flag per device |
| cfg_base_hi | input | 48 | Base address high byte, 8 bits per device |
| cfg_base_lo | input | 48 | Base address low byte, 8 bits per device |
| dev_sel | output | 6 | Chip select per device |
| reg_ofs | output | 3 | Register offset inside the winning window |
| any_hit | output | 1 | High when any select is high |

## Verification
Immediate assertions inside the decode slices are evaluated whenever the inputs change. They check that no select is high without both enables, without a legal base, or for an address outside the window. They also check that the winner grant is one-hot or empty and that the offset is zero when nothing is selected. Only the bench scenarios can show the other direction: that a select does go high at every address inside a legal window, that the window edges and range limits sit at the exact values, and that the lowest-index priority picks the right offset when bases are programmed to overlap. The random stimulus is aimed near the windows and the range limits so that both hits and misses occur often.

// File: rtl/sio_win_pkg.sv
package sio_win_pkg;

  localparam int NUM_DEV  = 6;
  localparam int ADDR_W   = 16;
  localparam int OFS_W    = 3;
  localparam int BASE_MIN = 16'h0100;

  typedef enum logic [1:0] {
    KIND_W8 = 2'd0,
    KIND_W4 = 2'd1,
    KIND_W1 = 2'd2
  } win_kind_e;

  // device index to window kind
  function automatic win_kind_e dev_kind(input int idx);
    if (idx < 3)      return KIND_W8;
    else if (idx < 5) return KIND_W4;
    else              return KIND_W1;
  endfunction

  function automatic int kind_span(input win_kind_e k);
    case (k)
      KIND_W8: return 8;
      KIND_W4: return 4;
      default: return 1;
    endcase
  endfunction

  // highest legal base: last address of the window stays below 0x1000
  function automatic int kind_base_max(input win_kind_e k);
    return 16'h1000 - kind_span(k);
  endfunction

  // window hit on a base and span
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int span);
    logic [ADDR_W:0] endp;
    endp = {1'b0, base} + ADDR_W'(span);
    return (addr >= base) && ({1'b0, addr} < endp);
  endfunction

endpackage

// File: rtl/sio_win_slot.sv
module sio_win_slot
  import sio_win_pkg::*;
#(
  parameter int SPAN     = 8,
  parameter int BASE_LO  = 16'h0100,
  parameter int BASE_HI  = 16'h0FF8
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              glb_en,
  input  logic              act_en,
  input  logic [7:0]        base_hi,
  input  logic [7:0]        base_lo,
  output logic              sel,
  output logic [OFS_W-1:0]  ofs
);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(SPAN - 1);

  logic [ADDR_W-1:0] base;
  logic              both_en;
  logic              base_ok;
  logic              hit;

  assign base    = {base_hi, base_lo};
  assign both_en = glb_en & act_en;
  assign base_ok = (base >= ADDR_W'(BASE_LO)) && (base <= ADDR_W'(BASE_HI));
  assign hit     = in_window(io_addr, base, SPAN);
  assign sel     = both_en & base_ok & hit;
  assign ofs     = io_addr[OFS_W-1:0] & OFS_MASK;

  always_comb begin
    if (sel === 1'b1) begin
      AST_SEL_NEEDS_EN: assert (glb_en === 1'b1 && act_en === 1'b1); // R1
      AST_SEL_BASE_LEGAL: assert ({base_hi, base_lo} >= 16'h0100 &&
                                  {base_hi, base_lo} <= ADDR_W'(BASE_HI)); // R3
      AST_SEL_IN_WINDOW: assert (io_addr >= {base_hi, base_lo} &&
                                 (io_addr - {base_hi, base_lo}) < ADDR_W'(SPAN)); // R4
    end
  end

endmodule

// File: rtl/sio_win_prio.sv
module sio_win_prio
  import sio_win_pkg::*;
#(
  parameter int N = NUM_DEV
) (
  input  logic [N-1:0]       req,
  input  logic [N*OFS_W-1:0] ofs_in,
  output logic [N-1:0]       grant,
  output logic [OFS_W-1:0]   ofs_out,
  output logic               any
);
  always_comb begin
    grant   = '0;
    ofs_out = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        ofs_out = ofs_in[i*OFS_W +: OFS_W];
      end
    end
  end

  assign any = |req;

  always_comb begin
    if (!$isunknown(req)) begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant) && ((grant & ~req) == '0)); // R6
      if (req == '0) begin
        AST_OFS_ZERO_IDLE: assert (ofs_out == '0 && grant == '0); // R5
      end
    end
  end

endmodule

// File: rtl/sio_addr_window.sv
module sio_addr_window
  import sio_win_pkg::*;
(
  input  logic [15:0] io_addr,
  input  logic [5:0]  cfg_glb_en,
  input  logic [5:0]  cfg_act,
  input  logic [47:0] cfg_base_hi,
  input  logic [47:0] cfg_base_lo,
  output logic [5:0]  dev_sel,
  output logic [2:0]  reg_ofs,
  output logic        any_hit
);
  logic [NUM_DEV*OFS_W-1:0] slot_ofs;
  logic [NUM_DEV-1:0]       win_grant;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
    localparam win_kind_e KIND = dev_kind(g);
    sio_win_slot #(
      .SPAN    (kind_span(KIND)),
      .BASE_LO (BASE_MIN),
      .BASE_HI (kind_base_max(KIND))
    ) slot_i (
      .io_addr (io_addr),
      .glb_en  (cfg_glb_en[g]),
      .act_en  (cfg_act[g]),
      .base_hi (cfg_base_hi[g*8 +: 8]),
      .base_lo (cfg_base_lo[g*8 +: 8]),
      .sel     (dev_sel[g]),
      .ofs     (slot_ofs[g*OFS_W +: OFS_W])
    );
  end

  sio_win_prio #(.N(NUM_DEV)) prio_i (
    .req     (dev_sel),
    .ofs_in  (slot_ofs),
    .grant   (win_grant),
    .ofs_out (reg_ofs),
    .any     (any_hit)
  );

  always_comb begin
    if (!$isunknown(dev_sel) && !$isunknown(win_grant)) begin
      AST_ANY_MATCHES_SEL: assert (any_hit == (win_grant != '0)); // R6
    end
  end

endmodule

// File: tb/sio_addr_window_tb.sv
module sio_addr_window_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] io_addr;
  logic [5:0]  glb, act;
  logic [47:0] bhi, blo;
  logic [5:0]  sel;
  logic [2:0]  ofs;
  logic        any;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  sio_addr_window dut_i (
    .io_addr(io_addr), .cfg_glb_en(glb), .cfg_act(act),
    .cfg_base_hi(bhi), .cfg_base_lo(blo),
    .dev_sel(sel), .reg_ofs(ofs), .any_hit(any)
  );

  function automatic int m_width(input int d);
    return (d <= 2) ? 8 : (d <= 4) ? 4 : 1;
  endfunction
  function automatic int m_max(input int d);
    return (d <= 2) ? 'h0FF8 : (d <= 4) ? 'h0FFC : 'h0FFF;
  endfunction
  function automatic int m_base(input int d);
    return (int'(bhi[d*8 +: 8]) * 256) + int'(blo[d*8 +: 8]);
  endfunction
  function automatic logic m_sel(input int d);
    int b;
    b = m_base(d);
    if (!(glb[d] && act[d])) return 1'b0;
    if (b < 'h100 || b > m_max(d)) return 1'b0;
    return (int'(io_addr) >= b) && (int'(io_addr) < b + m_width(d));
  endfunction

  task automatic set_base(input int d, input int b);
    bhi[d*8 +: 8] = 8'(b >> 8);
    blo[d*8 +: 8] = 8'(b);
  endtask

  task automatic check(input string tag);
    logic [5:0] es;
    logic [2:0] eo;
    eo = 3'd0;
    for (int d = 5; d >= 0; d--) begin
      es[d] = m_sel(d);
      if (es[d]) eo = 3'(int'(io_addr) % m_width(d));
    end
    n_chk++;
    if (sel !== es) begin
      n_fail++;
      $display("FAIL %s R1/R3/R4 sel addr=%h act=%b exp=%b", tag, io_addr, sel, es);
    end
    n_chk++;
    if (ofs !== eo) begin
      n_fail++;
      $display("FAIL %s R5 ofs addr=%h act=%0d exp=%0d", tag, io_addr, ofs, eo);
    end
    n_chk++;
    if (any !== (es != 0)) begin
      n_fail++;
      $display("FAIL %s R6 any act=%b exp=%b", tag, any, (es != 0));
    end
  endtask

  // drive on falling edge, sample 2 ns later (R7: no clock in the path)
  task automatic apply(input int a, input string tag);
    @(negedge clk);
    io_addr = 16'(a);
    #2;
    check(tag);
  endtask

  task automatic defaults();
    glb = 6'h3F; act = 6'h3F;
    set_base(0, 'h3F0); set_base(1, 'h3F8); set_base(2, 'h2F8);
    set_base(3, 'h378); set_base(4, 'h500); set_base(5, 'h0EA);
  endtask

  initial begin
    int s;
    s = $urandom(1234);
    io_addr = 16'h0; glb = '0; act = '0; bhi = '0; blo = '0;
    apply('h0, "reset_idle_R1");
    defaults();
    // R2/R4 legal windows and edges
    apply('h3F0, "R4_fdc_lo");  apply('h3F7, "R4_fdc_hi");
    apply('h3F8, "R4_serA_lo"); apply('h3FF, "R4_serA_hi");
    apply('h400, "R4_miss");    apply('h37B, "R4_par_hi");
    apply('h37C, "R4_par_out"); apply('h503, "R5_abus_ofs");
    // R3: aux I/O base below range
    apply('h0EA, "R3_aux_low");
    set_base(5, 'hFFF); apply('hFFF, "R3_aux_max");
    set_base(0, 'hFF8); apply('hFFF, "R3_fdc_max");
    set_base(0, 'hFF9); apply('hFF9, "R3_fdc_over");
    set_base(3, 'hFFC); apply('hFFF, "R3_par_max");
    set_base(3, 'hFFD); apply('hFFD, "R3_par_over");
    set_base(1, 'h100); apply('h100, "R3_ser_min");
    set_base(1, 'h0FF); apply('h0FF, "R3_ser_under");
    // R1 single enables
    defaults(); glb[1] = 1'b0; apply('h3F9, "R1_glb_off");
    glb[1] = 1'b1; act[1] = 1'b0; apply('h3F9, "R1_act_off");
    // R6 overlap: serial B sits on floppy, floppy wins offset
    defaults(); set_base(2, 'h3F3); apply('h3F5, "R6_overlap");
    glb[0] = 1'b0; apply('h3F5, "R6_overlap_lower_off");
    // random
    for (int i = 0; i < 3000; i++) begin
      int d;
      glb = 6'($urandom()) | 6'($urandom());
      act = 6'($urandom()) | 6'($urandom());
      for (int k = 0; k < 6; k++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r == 0)      set_base(k, $urandom_range(0, 'hFFFF));
        else if (r == 1) set_base(k, $urandom_range('hFF0, 'h1003));
        else if (r == 2) set_base(k, $urandom_range('hF8, 'h104));
        else             set_base(k, $urandom_range('h100, 'h400));
      end
      d = $urandom_range(0, 5);
      apply(m_base(d) + $urandom_range(0, 9) - 1, "rand");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7 act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule